// File: doc/BRIEF.md
# Context-Tagged Translation Cache with Access Check

This block keeps a small, fully associative set of recently resolved virtual-to-physical page translations and is consulted before any page-table walk starts. Each stored translation carries the process-context identifier it belongs to. A lookup presents a virtual page number, the current context and the kind of access: load, store or instruction fetch. In the same cycle the block answers whether a matching translation exists, which physical page it names, and whether the stored read/write/execute rights forbid the access. Because entries are tagged by context, switching between processes needs no flush.

Translations found by an external walker come in through a fill stream with a valid/ready handshake. The block applies back-pressure only while reset is held. Outside reset `fill_ready` is high, and every cycle with `fill_valid` high installs one translation at the next clock edge. Two plain control inputs remove entries. One clears the whole cache, for systems that do not use context tags. The other clears only the entries of one named context. Out of scope are the walk itself, pages shared across contexts and page sizes other than one.

Top module: `xlat_cache`

## Requirements
- R1: A lookup with `lk_valid` high whose context and virtual page equal those of a valid entry raises `lk_hit` in the same cycle, and `lk_ppn` carries that entry's physical page.
- R2: When no valid entry matches, or `lk_valid` is low, `lk_hit` and `lk_fault` are low and `lk_ppn` is zero.
- R3: An entry matches only a lookup whose context equals its own, so the same virtual page in another context misses.
- R4: `lk_acc` is encoded as 00 load, 01 store, 10 fetch and 11 reserved. `fill_perm` bit 2 is read, bit 1 is write and bit 0 is execute. A load needs read, a store needs write and a fetch needs execute. The reserved code is never allowed. `lk_fault` is high exactly when a hit lacks the needed right.
- R5: `flush_all` invalidates every entry at the next clock edge.
- R6: `flush_ctx_en` invalidates at the next edge only the entries whose context equals `flush_ctx_id`. All other entries are kept.
- R7: A fill is visible to lookups from the cycle after its handshake. When the pair is not already present, it goes into the lowest-numbered free entry.
- R8: When all 16 entries are valid, a fill of a new pair replaces the entry chosen by a round-robin pointer. The pointer starts at 0 after reset and advances by one, wrapping, only on such a replacement.
- R9: A fill whose (context, virtual page) pair is already present overwrites that entry, so at most one entry ever matches a lookup.
- R10: When a flush and a fill occur in the same cycle, the flush is applied first and the fill is installed after it, so the filled translation survives.
- R11: `fill_ready` is low during reset and high from the first clock edge after reset is released.
- R12: After reset every entry is invalid, and every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request present |
| lk_ctx | input | 12 | Context of the lookup |
| lk_vpn | input | 36 | Virtual page number to translate |
| lk_acc | input | 2 | Access kind: 00 load, 01 store, 10 fetch, 11 reserved |
| lk_hit | output | 1 | Matching translation present |
| lk_fault | output | 1 | Hit whose rights forbid the access |
| lk_ppn | output | 36 | Physical page of the hit, zero on miss |
| fill_valid | input | 1 | Fill translation offered |
| fill_ready | output | 1 | Fill can be accepted |
| fill_ctx | input | 12 | Context of the fill |
| fill_vpn | input | 36 | Virtual page of the fill |
| fill_ppn | input | 36 | Physical page of the fill |
| fill_perm | input | 3 | Rights: bit 2 read, bit 1 write, bit 0 execute |
| flush_all | input | 1 | Invalidate every entry |
| flush_ctx_en | input | 1 | Invalidate the entries of one context |
| flush_ctx_id | input | 12 | Context to invalidate |

## Verification
Some properties are checked on every cycle by the assertions. At most one entry matches any lookup. A fault never appears without a hit, and a miss drives a zero page. A full flush with no fill leaves nothing valid. An accepted fill is valid on the next cycle. The round-robin pointer moves only when a fill lands on a full cache.

Other behaviour is shown only by the bench's scenarios. These are the lowest-free placement, the eviction order when the cache is full, the overwrite of a repeated pair, the selective context flush and the ordering of a flush against a same-cycle fill. The bench compares each of them against a reference model driven by random and directed traffic.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [1:0] {
    ACC_LOAD  = 2'b00,
    ACC_STORE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_e;

  typedef struct packed {
    logic rd;
    logic wr;
    logic ex;
  } rights_t;
endpackage

// File: rtl/xlat_match.sv
// Parallel tag comparator: one compare slice per entry.
module xlat_match #(
  parameter int N     = 16,
  parameter int CTX_W = 12,
  parameter int VPN_W = 36
) (
  input  logic                       en,
  input  logic [N-1:0]               live,
  input  logic [N-1:0][CTX_W-1:0]    ent_ctx,
  input  logic [N-1:0][VPN_W-1:0]    ent_vpn,
  input  logic [CTX_W-1:0]           key_ctx,
  input  logic [VPN_W-1:0]           key_vpn,
  output logic [N-1:0]               match
);
  for (genvar g = 0; g < N; g++) begin : g_slice
    assign match[g] = en && live[g] && (ent_ctx[g] == key_ctx) && (ent_vpn[g] == key_vpn);
  end
endmodule

// File: rtl/xlat_perm.sv
// Access-right decoder for one lookup.
module xlat_perm
  import xlat_pkg::*;
(
  input  logic [1:0] acc,
  input  rights_t    rights,
  output logic       allow
);
  always_comb begin
    unique case (acc_e'(acc))
      ACC_LOAD:  allow = rights.rd;
      ACC_STORE: allow = rights.wr;
      ACC_FETCH: allow = rights.ex;
      default:   allow = 1'b0;
    endcase
  end
endmodule

// File: rtl/xlat_victim.sv
// Chooses the slot a fill is written to: existing pair, lowest free, then round robin.
module xlat_victim #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     free_vec,
  input  logic [N-1:0]     dup_vec,
  input  logic [IDX_W-1:0] rr_ptr,
  output logic [IDX_W-1:0] sel,
  output logic             evict
);
  logic [IDX_W-1:0] free_idx, dup_idx;

  always_comb begin
    free_idx = '0;
    dup_idx  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (free_vec[i]) free_idx = IDX_W'(i);
      if (dup_vec[i])  dup_idx  = IDX_W'(i);
    end
    if (|dup_vec) begin
      sel   = dup_idx;
      evict = 1'b0;
    end else if (|free_vec) begin
      sel   = free_idx;
      evict = 1'b0;
    end else begin
      sel   = rr_ptr;
      evict = 1'b1;
    end
  end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int N     = 16,
  parameter int CTX_W = 12,
  parameter int VPN_W = 36,
  parameter int PPN_W = 36
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [CTX_W-1:0] lk_ctx,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [1:0]       lk_acc,
  output logic             lk_hit,
  output logic             lk_fault,
  output logic [PPN_W-1:0] lk_ppn,
  input  logic             fill_valid,
  output logic             fill_ready,
  input  logic [CTX_W-1:0] fill_ctx,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic [2:0]       fill_perm,
  input  logic             flush_all,
  input  logic             flush_ctx_en,
  input  logic [CTX_W-1:0] flush_ctx_id
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]             valid_q;
  logic [N-1:0][CTX_W-1:0]  ctx_q;
  logic [N-1:0][VPN_W-1:0]  vpn_q;
  logic [N-1:0][PPN_W-1:0]  ppn_q;
  rights_t [N-1:0]          perm_q;
  logic [IDX_W-1:0]         rr_q;
  logic                     rdy_q;

  // ---------------- lookup path ----------------
  logic [N-1:0] lk_match;
  rights_t      hit_rights;
  logic         allow;

  xlat_match #(.N(N), .CTX_W(CTX_W), .VPN_W(VPN_W)) u_lk_match (
    .en(lk_valid), .live(valid_q), .ent_ctx(ctx_q), .ent_vpn(vpn_q),
    .key_ctx(lk_ctx), .key_vpn(lk_vpn), .match(lk_match)
  );

  always_comb begin
    lk_ppn     = '0;
    hit_rights = '0;
    for (int i = 0; i < N; i++) begin
      if (lk_match[i]) begin
        lk_ppn     = lk_ppn | ppn_q[i];
        hit_rights = hit_rights | perm_q[i];
      end
    end
  end

  xlat_perm u_perm (.acc(lk_acc), .rights(hit_rights), .allow(allow));

  assign lk_hit   = |lk_match;
  assign lk_fault = lk_hit && !allow;

  // ---------------- flush, then fill ----------------
  logic [N-1:0] ctx_kill;
  logic [N-1:0] valid_post;

  for (genvar g = 0; g < N; g++) begin : g_kill
    assign ctx_kill[g] = flush_ctx_en && (ctx_q[g] == flush_ctx_id);
  end

  always_comb begin
    if (flush_all) valid_post = '0;
    else           valid_post = valid_q & ~ctx_kill;
  end

  logic             fill_fire;
  logic [N-1:0]     dup_vec;
  logic [IDX_W-1:0] fill_sel;
  logic             fill_evict;

  assign fill_ready = rdy_q;
  assign fill_fire  = fill_valid && fill_ready;

  xlat_match #(.N(N), .CTX_W(CTX_W), .VPN_W(VPN_W)) u_fill_match (
    .en(fill_valid), .live(valid_post), .ent_ctx(ctx_q), .ent_vpn(vpn_q),
    .key_ctx(fill_ctx), .key_vpn(fill_vpn), .match(dup_vec)
  );

  xlat_victim #(.N(N), .IDX_W(IDX_W)) u_victim (
    .free_vec(~valid_post), .dup_vec(dup_vec), .rr_ptr(rr_q),
    .sel(fill_sel), .evict(fill_evict)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      rr_q    <= '0;
      rdy_q   <= 1'b0;
    end else begin
      rdy_q   <= 1'b1;
      valid_q <= valid_post;
      if (fill_fire) begin
        valid_q[fill_sel] <= 1'b1;
        if (fill_evict) begin
          if (rr_q == IDX_W'(N - 1)) rr_q <= '0;
          else                       rr_q <= rr_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_fire) begin
      ctx_q[fill_sel]  <= fill_ctx;
      vpn_q[fill_sel]  <= fill_vpn;
      ppn_q[fill_sel]  <= fill_ppn;
      perm_q[fill_sel] <= rights_t'(fill_perm);
    end
  end

  // ---------------- assertions ----------------
  p_one_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));

  p_fault_needs_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fault |-> lk_hit);

  p_miss_zero_ppn_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_ppn == '0) && !lk_fault);

  p_flush_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_all && !fill_fire) |=> (valid_q == '0));

  p_fill_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_fire |=> valid_q[$past(fill_sel)]);

  p_rr_only_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rr_q != $past(rr_q)) |-> $past(fill_fire && (&valid_post)));
endmodule

// File: tb/xlat_cache_bench.sv
module xlat_cache_bench;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [11:0] lk_ctx = '0;
  logic [35:0] lk_vpn = '0;
  logic [1:0]  lk_acc = '0;
  logic        lk_hit, lk_fault, fill_ready;
  logic [35:0] lk_ppn;
  logic        fill_valid = 1'b0;
  logic [11:0] fill_ctx = '0;
  logic [35:0] fill_vpn = '0;
  logic [35:0] fill_ppn = '0;
  logic [2:0]  fill_perm = '0;
  logic        flush_all = 1'b0;
  logic        flush_ctx_en = 1'b0;
  logic [11:0] flush_ctx_id = '0;

  int compared = 0;
  int mismatched = 0;

  always #10 clk = ~clk;

  xlat_cache u_xlat_cache (.*);

  // reference model
  logic        m_v   [N];
  logic [11:0] m_ctx [N];
  logic [35:0] m_vpn [N];
  logic [35:0] m_ppn [N];
  logic [2:0]  m_perm[N];
  int          m_rr;

  task automatic chk(string tag, string what, logic [35:0] got, logic [35:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  function automatic logic allowed(logic [1:0] acc, logic [2:0] p);
    case (acc)
      2'b00: return p[2];
      2'b01: return p[1];
      2'b10: return p[0];
      default: return 1'b0;
    endcase
  endfunction

  task automatic check_lookup(string tag);
    logic        eh = 1'b0;
    logic [35:0] ep = '0;
    logic        ef = 1'b0;
    for (int i = 0; i < N; i++)
      if (lk_valid && m_v[i] && m_ctx[i] == lk_ctx && m_vpn[i] == lk_vpn) begin
        eh = 1'b1;
        ep = m_ppn[i];
        ef = !allowed(lk_acc, m_perm[i]);
      end
    chk(tag, "hit", 36'(lk_hit), 36'(eh));
    chk(tag, "ppn", lk_ppn, ep);
    chk(tag, "fault", 36'(lk_fault), 36'(ef));
  endtask

  task automatic model_update();
    int sel = -1;
    if (flush_all) for (int i = 0; i < N; i++) m_v[i] = 1'b0;
    else if (flush_ctx_en)
      for (int i = 0; i < N; i++) if (m_ctx[i] == flush_ctx_id) m_v[i] = 1'b0;
    if (fill_valid) begin
      for (int i = 0; i < N; i++)
        if (sel < 0 && m_v[i] && m_ctx[i] == fill_ctx && m_vpn[i] == fill_vpn) sel = i;
      if (sel < 0) for (int i = 0; i < N; i++) if (sel < 0 && !m_v[i]) sel = i;
      if (sel < 0) begin
        sel = m_rr;
        m_rr = (m_rr + 1) % N;
      end
      m_v[sel] = 1'b1; m_ctx[sel] = fill_ctx; m_vpn[sel] = fill_vpn;
      m_ppn[sel] = fill_ppn; m_perm[sel] = fill_perm;
    end
  endtask

  // one cycle: drive at negedge, check lookup, commit at posedge
  task automatic cyc(string tag, logic lv, logic [11:0] lc, logic [35:0] lvp, logic [1:0] la,
                     logic fv, logic [11:0] fc, logic [35:0] fvp, logic [35:0] fp, logic [2:0] fpm,
                     logic fa, logic fce, logic [11:0] fci);
    @(negedge clk);
    lk_valid = lv; lk_ctx = lc; lk_vpn = lvp; lk_acc = la;
    fill_valid = fv; fill_ctx = fc; fill_vpn = fvp; fill_ppn = fp; fill_perm = fpm;
    flush_all = fa; flush_ctx_en = fce; flush_ctx_id = fci;
    #1;
    check_lookup(tag);
    chk(tag, "fill_ready", 36'(fill_ready), 36'(1));
    @(posedge clk);
    model_update();
  endtask

  task automatic fill(string tag, logic [11:0] c, logic [35:0] v, logic [35:0] p, logic [2:0] pm);
    cyc(tag, 1'b0, '0, '0, 2'b00, 1'b1, c, v, p, pm, 1'b0, 1'b0, '0);
  endtask

  task automatic look(string tag, logic [11:0] c, logic [35:0] v, logic [1:0] a);
    cyc(tag, 1'b1, c, v, a, 1'b0, '0, '0, '0, 3'b0, 1'b0, 1'b0, '0);
  endtask

  task automatic idle_flush(string tag, logic fa, logic fce, logic [11:0] fci);
    cyc(tag, 1'b0, '0, '0, 2'b00, 1'b0, '0, '0, '0, 3'b0, fa, fce, fci);
  endtask

  initial begin
    #3_000_000;
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5eed_0042);
    for (int i = 0; i < N; i++) begin
      m_v[i] = 1'b0; m_ctx[i] = '0; m_vpn[i] = '0; m_ppn[i] = '0; m_perm[i] = '0;
    end
    m_rr = 0;

    // R11, R12: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11", "fill_ready in reset", 36'(fill_ready), 36'(0));
    rst_n = 1'b1;
    @(posedge clk);
    look("R12", 12'h005, 36'h100, 2'b00);
    look("R12", 12'h000, 36'h000, 2'b10);

    // R1, R4: single entry with read right only
    fill("R7", 12'h005, 36'h100, 36'hABC, 3'b100);
    look("R1", 12'h005, 36'h100, 2'b00);
    look("R4", 12'h005, 36'h100, 2'b01);
    look("R4", 12'h005, 36'h100, 2'b10);
    look("R4", 12'h005, 36'h100, 2'b11);
    fill("R7", 12'h006, 36'h100, 36'h777, 3'b011);
    look("R3", 12'h006, 36'h100, 2'b01);
    look("R3", 12'h007, 36'h100, 2'b00);
    look("R2", 12'h005, 36'h101, 2'b00);

    // R9: overwrite of a repeated pair
    fill("R9", 12'h005, 36'h100, 36'hDEF, 3'b111);
    look("R9", 12'h005, 36'h100, 2'b10);

    // R6: flush context 5 only
    idle_flush("R6", 1'b0, 1'b1, 12'h005);
    look("R6", 12'h005, 36'h100, 2'b00);
    look("R6", 12'h006, 36'h100, 2'b10);

    // R7, R8: fill past capacity, check eviction order
    for (int i = 0; i < 20; i++) fill("R8", 12'h00A, 36'(32'h200 + i), 36'(32'h900 + i), 3'b110);
    for (int i = 0; i < 20; i++) look("R8", 12'h00A, 36'(32'h200 + i), 2'b01);
    look("R8", 12'h006, 36'h100, 2'b01);

    // R10: flush plus fill in the same cycle
    cyc("R10", 1'b0, '0, '0, 2'b00, 1'b1, 12'h00B, 36'h333, 36'h444, 3'b001, 1'b1, 1'b0, '0);
    look("R10", 12'h00B, 36'h333, 2'b10);
    look("R10", 12'h00A, 36'h210, 2'b01);
    cyc("R10", 1'b0, '0, '0, 2'b00, 1'b1, 12'h00C, 36'h555, 36'h666, 3'b100, 1'b0, 1'b1, 12'h00C);
    look("R10", 12'h00C, 36'h555, 2'b00);

    // R5: full flush
    fill("R7", 12'h001, 36'h010, 36'h020, 3'b111);
    idle_flush("R5", 1'b1, 1'b0, '0);
    look("R5", 12'h001, 36'h010, 2'b00);
    look("R5", 12'h00B, 36'h333, 2'b10);

    // random traffic over a narrow key space
    for (int n = 0; n < 4000; n++) begin
      logic [11:0] c  = 12'($urandom_range(0, 3));
      logic [35:0] v  = 36'($urandom_range(0, 9));
      logic        fv = ($urandom_range(0, 2) == 0);
      logic [11:0] fc = 12'($urandom_range(0, 3));
      logic [35:0] fvp = 36'($urandom_range(0, 9));
      logic [35:0] fp = {4'($urandom), 32'($urandom)};
      logic        fa = ($urandom_range(0, 99) == 0);
      logic        fce = ($urandom_range(0, 39) == 0);
      cyc("R1", 1'b1, c, v, 2'($urandom), fv, fc, fvp, fp, 3'($urandom),
          fa, fce, 12'($urandom_range(0, 3)));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule